// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This unit is a single-stage vector execution slice for integer multiply-accumulate. Each cycle it may accept an accumulator vector and two source vectors. Every 32-bit lane of the accumulator is increased by a small dot product taken from the matching 32 bits of the two sources. In byte form, each lane multiplies four unsigned bytes by four signed bytes. In word form, each lane multiplies two signed halfwords by two signed halfwords. The sum either wraps or is clamped to the signed 32-bit range.

A per-lane mask picks what is written for each lane: the computed value, or else the incoming accumulator (merge) or zero (zeroing). Operations run either on the full 256-bit vector or on its lower 128 bits only. Results are registered, so a valid input yields a valid output exactly one clock later.

Top module: `dotacc_unit`

## Requirements
- R1: With `in_op`=0 (byte form), the value of lane j is the accumulator lane plus the sum of four products. Each product multiplies an unsigned byte k of `in_a` lane j by a two's-complement byte k of `in_b` lane j, for k = 0..3, where byte k occupies lane bits [8k+7:8k].
- R2: With `in_op`=1 (word form), the value of lane j is the accumulator lane plus the sum of two products. Each product multiplies a signed halfword h of `in_a` lane j by a signed halfword h of `in_b` lane j, where halfword h occupies lane bits [16h+15:16h]. The case -32768 x -32768 is exact.
- R3: With `in_sat`=1, a complete lane sum (accumulator plus all products) above 2^31-1 is written as 32'h7FFF_FFFF. Sums already in range are unchanged.
- R4: With `in_sat`=1, a complete lane sum below -2^31 is written as 32'h8000_0000.
- R5: With `in_sat`=0, the complete lane sum is reduced modulo 2^32.
- R6: With `in_wide`=0, only lanes 0..3 (bits 127:0) are computed. Output bits 255:128 are zero, and mask bits 7:4 have no effect.
- R7: With `in_zero_mask`=0, an active lane whose `in_mask` bit is 0 is written with its `in_acc` lane. A lane whose mask bit is 1 always gets the computed value.
- R8: With `in_zero_mask`=1, an active lane whose `in_mask` bit is 0 is written as zero.
- R9: `out_valid` equals `in_valid` of the previous cycle, and `out_dst` carries the result of the operation accepted in that cycle.
- R10: While `in_valid` is low, `out_dst` keeps its last value whatever the other inputs do.
- R11: During reset, `out_valid` is 0 and `out_dst` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 1 | 0 = byte form, 1 = word form |
| in_sat | input | 1 | 1 = clamp to signed 32-bit, 0 = wrap |
| in_wide | input | 1 | 1 = 256-bit form (8 lanes), 0 = 128-bit form (4 lanes) |
| in_zero_mask | input | 1 | 1 = unselected lanes become zero, 0 = they keep the accumulator |
| in_mask | input | 8 | Lane select, bit j for lane j |
| in_acc | input | 256 | Accumulator vector, 32-bit lanes |
| in_a | input | 256 | First source (unsigned bytes or signed halfwords) |
| in_b | input | 256 | Second source (signed bytes or signed halfwords) |
| out_valid | output | 1 | Result present |
| out_dst | output | 256 | Destination vector |

## Verification
The hardest case to reach from the ports is a saturating lane whose sum leaves the 32-bit range by only a small amount. Random operands almost never place the accumulator next to a limit while the products push past it. The word-form case where both products equal 2^30 is just as rare. The stimulus therefore mixes uniform random vectors with vectors built only from the extreme codes 0x00, 0x7F, 0x80 and 0xFF and from accumulators at or next to the limits. Directed cases then hit each limit in both wrap and clamp form.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;

    localparam int DEF_VEC_W    = 256;
    localparam int DEF_NARROW_W = 128;
    localparam int DEF_LANE_W   = 32;
    localparam int DEF_BYTE_W   = 8;
    localparam int DEF_GUARD_W  = 3;

    typedef enum logic {
        OP_BYTE = 1'b0,
        OP_WORD = 1'b1
    } dotacc_op_e;

endpackage

// File: rtl/dotacc_lane.sv
// One 32-bit lane: forms the unclamped sum at a widened precision.
module dotacc_lane
    import dotacc_pkg::*;
#(
    parameter int LANE_W  = DEF_LANE_W,
    parameter int BYTE_W  = DEF_BYTE_W,
    parameter int GUARD_W = DEF_GUARD_W
) (
    input  logic                      op_word,
    input  logic [LANE_W-1:0]         a_lane,
    input  logic [LANE_W-1:0]         b_lane,
    input  logic [LANE_W-1:0]         acc_lane,
    output logic [LANE_W+GUARD_W-1:0] sum
);
    localparam int SUM_W  = LANE_W + GUARD_W;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int NB     = LANE_W / BYTE_W;
    localparam int NH     = LANE_W / HALF_W;
    localparam int BP_W   = 2 * BYTE_W + 2;
    localparam int HP_W   = 2 * HALF_W + 2;

    logic [BP_W-1:0] bprod [NB];
    logic [HP_W-1:0] hprod [NH];

    // unsigned byte of A times signed byte of B
    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic [BP_W-1:0] ua;
        logic [BP_W-1:0] sb;
        assign ua = {{(BP_W-BYTE_W){1'b0}}, a_lane[k*BYTE_W +: BYTE_W]};
        assign sb = {{(BP_W-BYTE_W){b_lane[k*BYTE_W+BYTE_W-1]}}, b_lane[k*BYTE_W +: BYTE_W]};
        assign bprod[k] = ua * sb;
    end

    // signed halfword times signed halfword
    for (genvar h = 0; h < NH; h++) begin : g_half
        logic [HP_W-1:0] sa;
        logic [HP_W-1:0] sb;
        assign sa = {{(HP_W-HALF_W){a_lane[h*HALF_W+HALF_W-1]}}, a_lane[h*HALF_W +: HALF_W]};
        assign sb = {{(HP_W-HALF_W){b_lane[h*HALF_W+HALF_W-1]}}, b_lane[h*HALF_W +: HALF_W]};
        assign hprod[h] = sa * sb;
    end

    always_comb begin
        sum = {{GUARD_W{acc_lane[LANE_W-1]}}, acc_lane};
        if (op_word == OP_WORD) begin
            for (int h = 0; h < NH; h++) begin
                sum = sum + {{(SUM_W-HP_W){hprod[h][HP_W-1]}}, hprod[h]};
            end
        end else begin
            for (int k = 0; k < NB; k++) begin
                sum = sum + {{(SUM_W-BP_W){bprod[k][BP_W-1]}}, bprod[k]};
            end
        end
    end

endmodule

// File: rtl/dotacc_sat.sv
// Reduces a widened lane sum to 32 bits: wrap or signed clamp.
module dotacc_sat #(
    parameter int LANE_W  = 32,
    parameter int GUARD_W = 3
) (
    input  logic                      sat_en,
    input  logic [LANE_W+GUARD_W-1:0] sum,
    output logic [LANE_W-1:0]         res
);
    localparam int SUM_W = LANE_W + GUARD_W;
    localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_LIM = {1'b1, {(LANE_W-1){1'b0}}};

    logic [GUARD_W:0] top_bits;
    logic             in_range;

    assign top_bits = sum[SUM_W-1:LANE_W-1];
    assign in_range = (&top_bits) | ~(|top_bits);

    always_comb begin
        if (!sat_en || in_range) begin
            res = sum[LANE_W-1:0];
        end else if (sum[SUM_W-1]) begin
            res = NEG_LIM;
        end else begin
            res = POS_LIM;
        end
    end

endmodule

// File: rtl/dotacc_unit.sv
module dotacc_unit
    import dotacc_pkg::*;
#(
    parameter int VEC_W    = DEF_VEC_W,
    parameter int NARROW_W = DEF_NARROW_W,
    parameter int LANE_W   = DEF_LANE_W,
    parameter int BYTE_W   = DEF_BYTE_W,
    parameter int GUARD_W  = DEF_GUARD_W,
    parameter int LANES    = VEC_W / LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic             in_sat,
    input  logic             in_wide,
    input  logic             in_zero_mask,
    input  logic [LANES-1:0] in_mask,
    input  logic [VEC_W-1:0] in_acc,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_dst
);
    localparam int SUM_W        = LANE_W + GUARD_W;
    localparam int NARROW_LANES = NARROW_W / LANE_W;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] dst;
    } stage_t;

    stage_t stage_d;
    stage_t stage_q;

    logic [LANES-1:0][LANE_W-1:0] lane_val;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SUM_W-1:0]  wide_sum;
        logic [LANE_W-1:0] fin;
        logic              lane_on;

        dotacc_lane #(
            .LANE_W  (LANE_W),
            .BYTE_W  (BYTE_W),
            .GUARD_W (GUARD_W)
        ) u_lane (
            .op_word  (in_op),
            .a_lane   (in_a[l*LANE_W +: LANE_W]),
            .b_lane   (in_b[l*LANE_W +: LANE_W]),
            .acc_lane (in_acc[l*LANE_W +: LANE_W]),
            .sum      (wide_sum)
        );

        dotacc_sat #(
            .LANE_W  (LANE_W),
            .GUARD_W (GUARD_W)
        ) u_sat (
            .sat_en (in_sat),
            .sum    (wide_sum),
            .res    (fin)
        );

        if (l < NARROW_LANES) begin : g_low
            assign lane_on = 1'b1;
        end else begin : g_high
            assign lane_on = in_wide;
        end

        always_comb begin
            if (!lane_on) begin
                lane_val[l] = '0;
            end else if (in_mask[l]) begin
                lane_val[l] = fin;
            end else if (in_zero_mask) begin
                lane_val[l] = '0;
            end else begin
                lane_val[l] = in_acc[l*LANE_W +: LANE_W];
            end
        end
    end

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.dst = lane_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign out_dst   = stage_q.dst;

endmodule

// File: rtl/dotacc_unit_chk.sv
module dotacc_unit_chk #(
    parameter int VEC_W    = 256,
    parameter int NARROW_W = 128,
    parameter int LANES    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_op,
    input logic             in_sat,
    input logic             in_wide,
    input logic             in_zero_mask,
    input logic [LANES-1:0] in_mask,
    input logic [VEC_W-1:0] in_acc,
    input logic [VEC_W-1:0] in_a,
    input logic [VEC_W-1:0] in_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_dst
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_dst));

    a_r6_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide) |=> (out_dst[VEC_W-1:NARROW_W] == '0));

    a_r8_all_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zero_mask && in_mask == '0) |=> (out_dst == '0));

    a_r7_all_merged: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_wide && !in_zero_mask && in_mask == '0)
            |=> (out_dst == $past(in_acc)));

    // R3: a clamped lane 0 whose accumulator is already at the top stays there
    a_r3_top_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sat && in_mask[0] && in_acc[31:0] == 32'h7FFF_FFFF
         && in_a[7:0] == 8'h01 && in_b[7:0] == 8'h01 && in_op == 1'b0
         && in_a[31:8] == '0) |=> (out_dst[31:0] == 32'h7FFF_FFFF));

endmodule

bind dotacc_unit dotacc_unit_chk chk_i (.*);

// File: tb/dotacc_unit_tb_top.sv
`timescale 1ns/1ps
module dotacc_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_op = 1'b0;
    logic         in_sat = 1'b0;
    logic         in_wide = 1'b1;
    logic         in_zero_mask = 1'b0;
    logic [7:0]   in_mask = '0;
    logic [255:0] in_acc = '0;
    logic [255:0] in_a = '0;
    logic [255:0] in_b = '0;
    logic         out_valid;
    logic [255:0] out_dst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dotacc_unit dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
        .in_sat (in_sat), .in_wide (in_wide), .in_zero_mask (in_zero_mask),
        .in_mask (in_mask), .in_acc (in_acc), .in_a (in_a), .in_b (in_b),
        .out_valid (out_valid), .out_dst (out_dst)
    );

    function automatic logic [31:0] ref_lane(input logic op, input logic sat,
            input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc);
        longint s;
        s = longint'($signed(acc));
        if (op) begin
            for (int h = 0; h < 2; h++)
                s += longint'($signed(a[16*h +: 16])) * longint'($signed(b[16*h +: 16]));
        end else begin
            for (int k = 0; k < 4; k++)
                s += longint'({56'd0, a[8*k +: 8]}) * longint'($signed(b[8*k +: 8]));
        end
        if (sat) begin
            if (s > 64'sd2147483647) s = 64'sd2147483647;
            if (s < -64'sd2147483648) s = -64'sd2147483648;
        end
        return s[31:0];
    endfunction

    function automatic logic [255:0] ref_vec(input logic op, input logic sat,
            input logic wide, input logic zm, input logic [7:0] mask,
            input logic [255:0] acc, input logic [255:0] a, input logic [255:0] b);
        logic [255:0] r;
        r = '0;
        for (int l = 0; l < 8; l++) begin
            if (l < 4 || wide) begin
                if (mask[l])
                    r[32*l +: 32] = ref_lane(op, sat, a[32*l +: 32], b[32*l +: 32], acc[32*l +: 32]);
                else if (!zm)
                    r[32*l +: 32] = acc[32*l +: 32];
            end
        end
        return r;
    endfunction

    function automatic logic [255:0] rand_vec(input int style);
        logic [255:0] v;
        logic [7:0] pick [4];
        pick[0] = 8'h00; pick[1] = 8'h7F; pick[2] = 8'h80; pick[3] = 8'hFF;
        for (int i = 0; i < 32; i++) begin
            if (style == 0) v[8*i +: 8] = 8'($urandom);
            else            v[8*i +: 8] = pick[$urandom % 4];
        end
        return v;
    endfunction

    function automatic logic [255:0] rand_acc();
        logic [255:0] v;
        logic [31:0] near [6];
        near[0] = 32'h7FFF_FFFF; near[1] = 32'h8000_0000; near[2] = 32'h7FFF_0000;
        near[3] = 32'h8000_FFFF; near[4] = 32'h0000_0000; near[5] = 32'hFFFF_FFFF;
        for (int l = 0; l < 8; l++) begin
            if ($urandom % 2) v[32*l +: 32] = near[$urandom % 6];
            else              v[32*l +: 32] = $urandom;
        end
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive at a falling edge, the posedge registers, sample at the next falling edge
    task automatic run_op(input string tag, input logic op, input logic sat,
            input logic wide, input logic zm, input logic [7:0] mask,
            input logic [255:0] acc, input logic [255:0] a, input logic [255:0] b);
        logic [255:0] exp;
        exp = ref_vec(op, sat, wide, zm, mask, acc, a, b);
        in_valid = 1'b1; in_op = op; in_sat = sat; in_wide = wide;
        in_zero_mask = zm; in_mask = mask; in_acc = acc; in_a = a; in_b = b;
        @(negedge clk);
        check_bit({tag, " valid"}, out_valid, 1'b1);
        check_vec(tag, out_dst, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check_bit("R11 valid", out_valid, 1'b0);
        check_vec("R11 dst", out_dst, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all bytes 0xFF against 0x80 -> each lane -130560
        run_op("R1 ff_x_80", 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, '0, {32{8'hFF}}, {32{8'h80}});
        check_vec("R1 literal", out_dst, {8{32'hFFFE_0200}});

        // R2/R5: halfwords 0x8000 squared twice -> 2^31 wraps negative
        run_op("R5 word_wrap", 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, '0, {16{16'h8000}}, {16{16'h8000}});
        check_vec("R5 literal", out_dst, {8{32'h8000_0000}});
        // R3: same sum clamped
        run_op("R3 word_clamp", 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, '0, {16{16'h8000}}, {16{16'h8000}});
        check_vec("R3 literal", out_dst, {8{32'h7FFF_FFFF}});
        // R2: small exact word case 3*-2 + -4*5 + 100 = 74
        run_op("R2 word_small", 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, {8{32'd100}},
               {8{16'hFFFC, 16'h0003}}, {8{16'h0005, 16'hFFFE}});
        check_vec("R2 literal", out_dst, {8{32'd74}});

        // R3: top accumulator plus four, byte form; R5 wrap variant
        run_op("R3 acc_top", 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, {8{32'h7FFF_FFFF}}, {32{8'h01}}, {32{8'h01}});
        check_vec("R3 acc_top literal", out_dst, {8{32'h7FFF_FFFF}});
        run_op("R5 acc_top", 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, {8{32'h7FFF_FFFF}}, {32{8'h01}}, {32{8'h01}});
        check_vec("R5 acc_top literal", out_dst, {8{32'h8000_0003}});
        // R4: bottom accumulator pushed further down
        run_op("R4 acc_bottom", 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, {8{32'h8000_0000}}, {32{8'hFF}}, {32{8'h80}});
        check_vec("R4 literal", out_dst, {8{32'h8000_0000}});
        run_op("R4 word_bottom", 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, {8{32'h8000_0000}},
               {16{16'h7FFF}}, {16{16'h8000}});

        // R6: narrow form, upper mask bits ignored
        begin
            logic [255:0] ra, rb, rc, keep;
            ra = rand_vec(0); rb = rand_vec(0); rc = rand_acc();
            run_op("R6 narrow_ff", 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, rc, ra, rb);
            keep = out_dst;
            check_vec("R6 upper_zero", {out_dst[255:128], 128'd0}, '0);
            run_op("R6 narrow_0f", 1'b0, 1'b0, 1'b0, 1'b0, 8'h0F, rc, ra, rb);
            check_vec("R6 mask_high_ignored", out_dst, keep);
            run_op("R6 narrow_merge_f0", 1'b1, 1'b1, 1'b0, 1'b0, 8'hF0, rc, ra, rb);
        end

        // R7 / R8: alternating and empty masks
        begin
            logic [255:0] ra, rb, rc;
            ra = rand_vec(1); rb = rand_vec(1); rc = rand_acc();
            run_op("R7 merge_55", 1'b0, 1'b1, 1'b1, 1'b0, 8'h55, rc, ra, rb);
            run_op("R7 merge_00", 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, rc, ra, rb);
            check_vec("R7 merge_00 literal", out_dst, rc);
            run_op("R8 zero_aa", 1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, rc, ra, rb);
            run_op("R8 zero_00", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, rc, ra, rb);
            check_vec("R8 zero_00 literal", out_dst, '0);
        end

        // R9 / R10: idle cycle holds, valid drops
        begin
            logic [255:0] keep;
            run_op("R9 before_idle", 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, rand_acc(), rand_vec(0), rand_vec(0));
            keep = out_dst;
            in_valid = 1'b0; in_acc = rand_acc(); in_a = rand_vec(0); in_b = rand_vec(0);
            in_mask = 8'h3C; in_op = 1'b1;
            @(negedge clk);
            check_bit("R9 idle_valid", out_valid, 1'b0);
            check_vec("R10 hold", out_dst, keep);
            @(negedge clk);
            check_vec("R10 hold_2", out_dst, keep);
        end

        // R1/R2 random mix
        for (int n = 0; n < 1500; n++) begin
            logic op, sat, wide, zm;
            logic [7:0] mask;
            op = 1'($urandom); sat = 1'($urandom); wide = ($urandom % 4) != 0;
            zm = 1'($urandom);
            mask = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            run_op(op ? "R2 random" : "R1 random", op, sat, wide, zm, mask,
                   rand_acc(), rand_vec($urandom % 2), rand_vec($urandom % 2));
            if ($urandom % 8 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                check_bit("R9 random_idle", out_valid, 1'b0);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20240611);
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule